// File: doc/BRIEF.md
# DMA Address Translation Table Unit

This block translates the bus addresses that a device presents for DMA into physical addresses, using a table of per-page entries held in on-chip registers. The table covers a single DMA window that starts at bus address zero and is `WINDOW_BYTES` long. It is cut into 4 KiB pages, and each page has one 64-bit entry. The upper bits of an entry give the physical page frame. The two lowest bits grant read and write rights.

A translation request carries a bus address and a direction flag. One cycle later the block answers with a status code. On success it also gives the physical address and the number of bytes left before the end of the page, so the requester can split a burst at the page boundary.

An update request carries a 64-bit logical bus number, a bus address and a new entry value. The block accepts it only when the bus number names this window and the page lies inside the window. It answers one cycle later with an ok/error flag. A window size of zero builds no table at all, and every request is then refused.

Top module: `tce_xlate_unit`

## Requirements
- R1: After reset `xl_valid` and `up_valid` are low, and every entry is zero. As a result, every in-window translation returns the permission status until the page has been written.
- R2: Each cycle with `xl_req` high produces exactly one cycle of `xl_valid` on the next cycle. `xl_valid` is never high in any other cycle. The same rule links `up_req` and `up_valid`.
- R3: A translation whose bus address is greater than or equal to `WINDOW_BYTES` returns status 1 (out of bounds), whatever the table holds. Any status other than 0 comes with `xl_paddr` and `xl_len` both zero.
- R4: The entry rights are held in bits [1:0]: bit 0 grants read and bit 1 grants write. A request with `xl_to_mem`=1 (device writes memory) needs bit 1. A request with `xl_to_mem`=0 needs bit 0. A missing right gives status 2 (permission denied).
- R5: On status 0 (ok), `xl_paddr` is the entry with bits [11:0] cleared, ORed with bits [11:0] of the bus address.
- R6: On status 0, `xl_len` equals 4096 minus the in-page offset, bus address bits [11:0]. The value ranges from 1 to 4096.
- R7: An accepted update aligns its bus address down to a 4 KiB boundary and writes `up_entry` to the entry for page (address >> 12). It then reports `up_ok`=1.
- R8: An update whose bus address is greater than or equal to `WINDOW_BYTES` reports `up_ok`=0 and writes no entry.
- R9: An update whose `up_lbn` has any of bits [63:32] set, or whose low 32 bits differ from `LBN`, reports `up_ok`=0 and writes no entry.
- R10: When an update and a translation address the same entry in the same cycle, the translation sees the entry value from before the update.
- R11: With `WINDOW_BYTES`=0, every translation returns status 1 and every update reports `up_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xl_req | input | 1 | Translation request strobe |
| xl_addr | input | ADDR_W | Bus address to translate |
| xl_to_mem | input | 1 | 1 = device writes memory, 0 = device reads memory |
| xl_valid | output | 1 | Translation response strobe |
| xl_status | output | 2 | 0 ok, 1 out of bounds, 2 permission denied |
| xl_paddr | output | ENTRY_W | Translated physical address |
| xl_len | output | PAGE_SHIFT+1 | Bytes left to the page boundary |
| up_req | input | 1 | Update request strobe |
| up_lbn | input | 64 | Logical bus number of the update |
| up_addr | input | ADDR_W | Bus address of the page to update |
| up_entry | input | ENTRY_W | New entry value |
| up_valid | output | 1 | Update response strobe |
| up_ok | output | 1 | 1 = entry written, 0 = parameter error |

## Verification
The assertions assume that both request strobes stay low while reset is high. They also assume that `WINDOW_BYTES` is a multiple of the page size, so that checking an update's raw address against the window gives the same answer as checking its aligned address. The bench holds every strobe low during reset and keeps the default window at sixteen whole pages. It drives each request with full-width addresses and bus numbers, including all-ones values and values one page past the window. A second instance built with a zero window covers the empty case.

// File: rtl/tce_pkg.sv
package tce_pkg;

    typedef enum logic [1:0] {
        XS_OK   = 2'd0,
        XS_OOB  = 2'd1,
        XS_PERM = 2'd2
    } xl_status_e;

    localparam int unsigned RIGHT_RD_BIT = 0;
    localparam int unsigned RIGHT_WR_BIT = 1;

    typedef struct packed {
        logic       valid;
        xl_status_e status;
    } xl_tag_t;

    function automatic logic right_granted(input logic [1:0] rights, input logic to_mem);
        return to_mem ? rights[RIGHT_WR_BIT] : rights[RIGHT_RD_BIT];
    endfunction

endpackage

// File: rtl/tce_store.sv
module tce_store #(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned ENTRY_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data
);
    localparam logic [IDX_W:0] DEPTH_L = DEPTH[IDX_W:0];

    logic [ENTRY_W-1:0] mem [DEPTH];

    // Read is combinational on the current contents: a write landing at the
    // same edge is not yet visible (read before write).
    always_comb begin
        rd_data = '0;
        if ({1'b0, rd_idx} < DEPTH_L) rd_data = mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (wr_en && ({1'b0, wr_idx} < DEPTH_L)) begin
            mem[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/tce_walk.sv
module tce_walk
    import tce_pkg::*;
#(
    parameter int unsigned     ADDR_W       = 32,
    parameter int unsigned     ENTRY_W      = 64,
    parameter int unsigned     PAGE_SHIFT   = 12,
    parameter longint unsigned WINDOW_BYTES = 64'h1_0000
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                to_mem,
    input  logic [ENTRY_W-1:0]  entry,
    output xl_status_e          status,
    output logic [ENTRY_W-1:0]  paddr,
    output logic [PAGE_SHIFT:0] len
);
    localparam logic [ADDR_W:0] WIN_L = WINDOW_BYTES[ADDR_W:0];

    logic                  in_win;
    logic [PAGE_SHIFT-1:0] offset;

    assign in_win = ({1'b0, addr} < WIN_L);
    assign offset = addr[PAGE_SHIFT-1:0];

    always_comb begin
        status = XS_OK;
        paddr  = '0;
        len    = '0;
        if (!in_win) begin
            status = XS_OOB;
        end else if (!right_granted(entry[1:0], to_mem)) begin
            status = XS_PERM;
        end else begin
            paddr = {entry[ENTRY_W-1:PAGE_SHIFT], offset};
            len   = {1'b0, ~offset} + {{PAGE_SHIFT{1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/tce_upd_check.sv
module tce_upd_check #(
    parameter int unsigned     ADDR_W       = 32,
    parameter int unsigned     PAGE_SHIFT   = 12,
    parameter longint unsigned WINDOW_BYTES = 64'h1_0000,
    parameter logic [31:0]     LBN          = 32'h0000_1001
) (
    input  logic [63:0]       lbn,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] page_addr,
    output logic              accept
);
    localparam logic [ADDR_W:0]   WIN_L     = WINDOW_BYTES[ADDR_W:0];
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);

    logic lbn_match;

    assign page_addr = addr & ~PAGE_MASK;
    assign lbn_match = (lbn[63:32] == 32'd0) && (lbn[31:0] == LBN);
    assign accept    = lbn_match && ({1'b0, page_addr} < WIN_L);
endmodule

// File: rtl/tce_xlate_unit.sv
module tce_xlate_unit
    import tce_pkg::*;
#(
    parameter int unsigned     ADDR_W       = 32,
    parameter int unsigned     ENTRY_W      = 64,
    parameter int unsigned     PAGE_SHIFT   = 12,
    parameter longint unsigned WINDOW_BYTES = 64'h1_0000,
    parameter logic [31:0]     LBN          = 32'h0000_1001
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                xl_req,
    input  logic [ADDR_W-1:0]   xl_addr,
    input  logic                xl_to_mem,
    output logic                xl_valid,
    output logic [1:0]          xl_status,
    output logic [ENTRY_W-1:0]  xl_paddr,
    output logic [PAGE_SHIFT:0] xl_len,
    input  logic                up_req,
    input  logic [63:0]         up_lbn,
    input  logic [ADDR_W-1:0]   up_addr,
    input  logic [ENTRY_W-1:0]  up_entry,
    output logic                up_valid,
    output logic                up_ok
);
    localparam int unsigned DEPTH = int'(WINDOW_BYTES >> PAGE_SHIFT);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0]   rd_idx;
    logic [IDX_W-1:0]   wr_idx;
    logic [ENTRY_W-1:0] rd_entry;
    logic [ADDR_W-1:0]  up_page_addr;
    logic               up_accept;
    xl_status_e         walk_status;
    logic [ENTRY_W-1:0] walk_paddr;
    logic [PAGE_SHIFT:0] walk_len;
    xl_tag_t            tag_q;

    assign rd_idx = xl_addr[PAGE_SHIFT +: IDX_W];
    assign wr_idx = up_page_addr[PAGE_SHIFT +: IDX_W];

    generate
        if (DEPTH > 0) begin : g_table
            tce_store #(
                .DEPTH  (DEPTH),
                .IDX_W  (IDX_W),
                .ENTRY_W(ENTRY_W)
            ) u_store (
                .clk    (clk),
                .rst    (rst),
                .rd_idx (rd_idx),
                .rd_data(rd_entry),
                .wr_en  (up_req && up_accept),
                .wr_idx (wr_idx),
                .wr_data(up_entry)
            );
        end else begin : g_no_table
            assign rd_entry = '0;
        end
    endgenerate

    tce_walk #(
        .ADDR_W      (ADDR_W),
        .ENTRY_W     (ENTRY_W),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .WINDOW_BYTES(WINDOW_BYTES)
    ) u_walk (
        .addr  (xl_addr),
        .to_mem(xl_to_mem),
        .entry (rd_entry),
        .status(walk_status),
        .paddr (walk_paddr),
        .len   (walk_len)
    );

    tce_upd_check #(
        .ADDR_W      (ADDR_W),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .WINDOW_BYTES(WINDOW_BYTES),
        .LBN         (LBN)
    ) u_upd (
        .lbn      (up_lbn),
        .addr     (up_addr),
        .page_addr(up_page_addr),
        .accept   (up_accept)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q    <= '{valid: 1'b0, status: XS_OK};
            xl_paddr <= '0;
            xl_len   <= '0;
            up_valid <= 1'b0;
            up_ok    <= 1'b0;
        end else begin
            tag_q.valid <= xl_req;
            if (xl_req) begin
                tag_q.status <= walk_status;
                xl_paddr     <= walk_paddr;
                xl_len       <= walk_len;
            end
            up_valid <= up_req;
            up_ok    <= up_req && up_accept;
        end
    end

    assign xl_valid  = tag_q.valid;
    assign xl_status = tag_q.status;
endmodule

// File: rtl/tce_xlate_unit_chk.sv
module tce_xlate_unit_chk #(
    parameter int unsigned     ADDR_W       = 32,
    parameter int unsigned     ENTRY_W      = 64,
    parameter int unsigned     PAGE_SHIFT   = 12,
    parameter longint unsigned WINDOW_BYTES = 64'h1_0000
) (
    input logic                clk,
    input logic                rst,
    input logic                xl_req,
    input logic [ADDR_W-1:0]   xl_addr,
    input logic                xl_valid,
    input logic [1:0]          xl_status,
    input logic [ENTRY_W-1:0]  xl_paddr,
    input logic [PAGE_SHIFT:0] xl_len,
    input logic                up_req,
    input logic [63:0]         up_lbn,
    input logic [ADDR_W-1:0]   up_addr,
    input logic                up_valid,
    input logic                up_ok
);
    localparam logic [ADDR_W:0]     WIN_L  = WINDOW_BYTES[ADDR_W:0];
    localparam logic [PAGE_SHIFT:0] PAGE_L = (PAGE_SHIFT+1)'(64'd1 << PAGE_SHIFT);

    p_resp_next_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && xl_req) |=> xl_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        (!xl_req) |=> !xl_valid);

    p_upd_resp_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && up_req) |=> up_valid);

    p_oob_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && xl_req && ({1'b0, xl_addr} >= WIN_L)) |=> (xl_status == 2'd1));

    p_fault_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (xl_valid && xl_status != 2'd0) |-> (xl_len == '0 && xl_paddr == '0));

    p_offset_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && xl_req) |=>
            (xl_status != 2'd0 || xl_paddr[PAGE_SHIFT-1:0] == $past(xl_addr[PAGE_SHIFT-1:0])));

    p_len_r6: assert property (@(posedge clk) disable iff (rst)
        (xl_valid && xl_status == 2'd0) |->
            (({1'b0, xl_paddr[PAGE_SHIFT-1:0]} + xl_len) == PAGE_L));

    p_upd_oob_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && up_req && ({1'b0, up_addr} >= WIN_L)) |=> !up_ok);

    p_lbn_high_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && up_req && up_lbn[63:32] != 32'd0) |=> (up_valid && !up_ok));
endmodule

bind tce_xlate_unit tce_xlate_unit_chk #(
    .ADDR_W      (ADDR_W),
    .ENTRY_W     (ENTRY_W),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .WINDOW_BYTES(WINDOW_BYTES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .xl_req   (xl_req),
    .xl_addr  (xl_addr),
    .xl_valid (xl_valid),
    .xl_status(xl_status),
    .xl_paddr (xl_paddr),
    .xl_len   (xl_len),
    .up_req   (up_req),
    .up_lbn   (up_lbn),
    .up_addr  (up_addr),
    .up_valid (up_valid),
    .up_ok    (up_ok)
);

// File: tb/tce_xlate_unit_test.sv
module tce_xlate_unit_test;
    localparam int          CLK_PERIOD = 10;
    localparam longint      WIN        = 64'h1_0000;
    localparam logic [31:0] MY_LBN     = 32'h0000_1001;
    localparam int          NPG        = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xl_req = 1'b0;
    logic [31:0] xl_addr = '0;
    logic        xl_to_mem = 1'b0;
    logic        xl_valid;
    logic [1:0]  xl_status;
    logic [63:0] xl_paddr;
    logic [12:0] xl_len;
    logic        up_req = 1'b0;
    logic [63:0] up_lbn = '0;
    logic [31:0] up_addr = '0;
    logic [63:0] up_entry = '0;
    logic        up_valid;
    logic        up_ok;

    logic        e_xl_req = 1'b0;
    logic [31:0] e_xl_addr = '0;
    logic        e_xl_valid;
    logic [1:0]  e_xl_status;
    logic [63:0] e_xl_paddr;
    logic [12:0] e_xl_len;
    logic        e_up_req = 1'b0;
    logic        e_up_valid;
    logic        e_up_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    tce_xlate_unit #(.WINDOW_BYTES(WIN), .LBN(MY_LBN)) uut (
        .clk(clk), .rst(rst),
        .xl_req(xl_req), .xl_addr(xl_addr), .xl_to_mem(xl_to_mem),
        .xl_valid(xl_valid), .xl_status(xl_status), .xl_paddr(xl_paddr), .xl_len(xl_len),
        .up_req(up_req), .up_lbn(up_lbn), .up_addr(up_addr), .up_entry(up_entry),
        .up_valid(up_valid), .up_ok(up_ok)
    );

    tce_xlate_unit #(.WINDOW_BYTES(0), .LBN(MY_LBN)) uut_empty (
        .clk(clk), .rst(rst),
        .xl_req(e_xl_req), .xl_addr(e_xl_addr), .xl_to_mem(1'b0),
        .xl_valid(e_xl_valid), .xl_status(e_xl_status), .xl_paddr(e_xl_paddr), .xl_len(e_xl_len),
        .up_req(e_up_req), .up_lbn({32'd0, MY_LBN}), .up_addr(32'd0), .up_entry(64'h3),
        .up_valid(e_up_valid), .up_ok(e_up_ok)
    );

    typedef struct {
        logic [1:0]  st;
        logic [63:0] pa;
        logic [12:0] len;
        string       tag;
    } xl_exp_t;

    typedef struct {
        logic  ok;
        string tag;
    } up_exp_t;

    xl_exp_t     xq[$];
    up_exp_t     uq[$];
    logic [63:0] shadow [NPG];
    int          n_chk = 0;
    int          n_fail = 0;

    function automatic xl_exp_t model_xl(input logic [31:0] a, input bit m, input string tag);
        xl_exp_t r;
        logic [63:0] e;
        r.tag = tag; r.st = 2'd0; r.pa = '0; r.len = '0;
        if ({32'd0, a} >= WIN) begin
            r.st = 2'd1;
        end else begin
            e = shadow[a[15:12]];
            if (!(m ? e[1] : e[0])) begin
                r.st = 2'd2;
            end else begin
                r.pa  = {e[63:12], a[11:0]};
                r.len = 13'h1000 - {1'b0, a[11:0]};
            end
        end
        return r;
    endfunction

    task automatic cyc(input bit dx, input logic [31:0] xa, input bit xm,
                       input bit du, input logic [63:0] lbn, input logic [31:0] ua,
                       input logic [63:0] ue, input string tag);
        xl_exp_t xe;
        up_exp_t ux;
        logic [31:0] al;
        @(negedge clk);
        xl_req = dx; xl_addr = xa; xl_to_mem = xm;
        up_req = du; up_lbn = lbn; up_addr = ua; up_entry = ue;
        if (dx) begin
            xe = model_xl(xa, xm, tag);
            xq.push_back(xe);
        end
        if (du) begin
            al = ua & 32'hFFFF_F000;
            ux.tag = tag;
            ux.ok = (lbn[63:32] == 32'd0) && (lbn[31:0] == MY_LBN) && ({32'd0, al} < WIN);
            uq.push_back(ux);
            if (ux.ok) shadow[al[15:12]] = ue;
        end
    endtask

    task automatic xl(input logic [31:0] a, input bit m, input string tag);
        cyc(1'b1, a, m, 1'b0, '0, '0, '0, tag);
    endtask

    task automatic up(input logic [63:0] lbn, input logic [31:0] a, input logic [63:0] e, input string tag);
        cyc(1'b0, '0, 1'b0, 1'b1, lbn, a, e, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        xl_req = 1'b0; up_req = 1'b0; e_xl_req = 1'b0; e_up_req = 1'b0;
    endtask

    // Scoreboard monitor: pops one expected item per response strobe.
    always @(negedge clk) begin
        if (!rst) begin
            if (xl_valid) begin
                n_chk++;
                if (xq.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2: xl_valid high with no request, got 1 expected 0");
                end else begin
                    xl_exp_t x;
                    x = xq.pop_front();
                    if (xl_status !== x.st || xl_paddr !== x.pa || xl_len !== x.len) begin
                        n_fail++;
                        $display("FAIL %s: got st=%0d pa=%h len=%0d expected st=%0d pa=%h len=%0d",
                                 x.tag, xl_status, xl_paddr, xl_len, x.st, x.pa, x.len);
                    end
                end
            end
            if (up_valid) begin
                n_chk++;
                if (uq.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2: up_valid high with no request, got 1 expected 0");
                end else begin
                    up_exp_t u;
                    u = uq.pop_front();
                    if (up_ok !== u.ok) begin
                        n_fail++;
                        $display("FAIL %s: up_ok got %0b expected %0b", u.tag, up_ok, u.ok);
                    end
                end
            end
        end
    end

    task automatic check(input bit cond, input string msg, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", msg, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NPG; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(xl_valid === 1'b0 && up_valid === 1'b0, "R1 reset strobes",
              {62'd0, xl_valid, up_valid}, 64'd0);

        // R1: unwritten pages fault in both directions
        xl(32'h0000_0000, 1'b0, "R1 empty page read");
        xl(32'h0000_F123, 1'b1, "R1 empty page write");
        // R3: outside the window
        xl(32'h0001_0000, 1'b0, "R3 first byte past window");
        xl(32'hFFFF_FFFF, 1'b1, "R3 top address");
        // R7: unaligned update lands on page 3, read-only
        up({32'd0, MY_LBN}, 32'h0000_3456, 64'h0000_00AB_CDE0_0001, "R7 update page 3");
        xl(32'h0000_3000, 1'b0, "R5 R6 page start");
        xl(32'h0000_3FFF, 1'b0, "R6 last byte of page");
        xl(32'h0000_3800, 1'b1, "R4 write to read-only page");
        // R4: write-only page
        up({32'd0, MY_LBN}, 32'h0000_5000, 64'h0000_0001_2345_6002, "R7 update page 5");
        xl(32'h0000_5800, 1'b0, "R4 read of write-only page");
        xl(32'h0000_5800, 1'b1, "R4 R6 write to write-only page");
        up({32'd0, MY_LBN}, 32'h0000_7FFF, 64'hFEDC_BA98_7654_3FFF, "R7 update page 7");
        xl(32'h0000_7ABC, 1'b0, "R5 read-write page read");
        xl(32'h0000_7001, 1'b1, "R5 read-write page write");
        // R9: bad bus numbers write nothing
        up({32'h0000_0001, MY_LBN}, 32'h0000_7000, 64'h0, "R9 upper lbn bits");
        up({32'd0, MY_LBN ^ 32'h1}, 32'h0000_7000, 64'h0, "R9 wrong lbn");
        xl(32'h0000_7ABC, 1'b1, "R9 page 7 unchanged");
        // R8: out-of-window updates write nothing (0x10000 would alias page 0)
        up({32'd0, MY_LBN}, 32'h0001_0000, 64'h3, "R8 update past window");
        up({32'd0, MY_LBN}, 32'hFFFF_F000, 64'h3, "R8 update top page");
        xl(32'h0000_0010, 1'b0, "R8 page 0 still faults");
        // R10: simultaneous update and translation of page 3
        cyc(1'b1, 32'h0000_3010, 1'b1, 1'b1, {32'd0, MY_LBN}, 32'h0000_3000,
            64'h0000_0000_1111_1003, "R10 same-cycle old value");
        xl(32'h0000_3010, 1'b1, "R10 new value next cycle");
        // R5 R6 sweep across all pages
        for (int p = 0; p < NPG; p++)
            up({32'd0, MY_LBN}, 32'(p * 4096 + p * 16), 64'h0000_0012_3400_0000 | 64'(p << 12) | 64'(p % 4),
               "R7 sweep update");
        for (int p = 0; p < NPG; p++)
            xl(32'(p * 4096 + p * 255), p[0], "R5 R6 sweep translate");
        idle();

        // R11: zero-sized window refuses everything
        @(negedge clk);
        e_xl_req = 1'b1; e_xl_addr = 32'h0; e_up_req = 1'b1;
        @(negedge clk);
        e_xl_req = 1'b0; e_up_req = 1'b0;
        check(e_xl_valid === 1'b1 && e_xl_status === 2'd1, "R11 empty window translate",
              {61'd0, e_xl_valid, e_xl_status}, 64'h5);
        check(e_up_valid === 1'b1 && e_up_ok === 1'b0, "R11 empty window update",
              {62'd0, e_up_valid, e_up_ok}, 64'h2);

        repeat (2) @(negedge clk);
        check(xq.size() == 0, "R2 missing translation responses", 64'(xq.size()), 64'd0);
        check(uq.size() == 0, "R2 missing update responses", 64'(uq.size()), 64'd0);
        finish_run();
    end
endmodule